// File: doc/BRIEF.md
# Half-Duplex Variable-Width Bus Slave

This block is the peripheral end of a clocked, half-duplex link. The master drives a serial clock and an active-low select. Data travels over one shared data bus whose active lane count (1, 2, 4 or 8) the master picks for each transaction. The slave also owns a single status return line. Write bytes from the master go into a local receive FIFO. Read bytes for the master come from a local transmit FIFO. Neither FIFO is part of the block.

Each selected transaction opens with an 8-bit command on lane 0. The command names the direction and the lane count. For a write, data chunks follow at once. For a read, one turnaround clock passes first, and then the slave drives the lanes. After every byte the slave returns ACK or NAK on the status line. Once a NAK is given, the slave ignores the rest of the transaction. While the select is inactive the slave can show the fill state of both FIFOs, and this can be switched off when several slaves share the wires. Inputs are sampled on rising clock edges. Registered outputs change on falling edges. Deasserting the select resets the transaction logic at once, without waiting for a clock edge.

Top module: `hdx_slave`

## Requirements
- R1: With `ss_n` high and `status_en` high, only lane 0 of the data bus is driven (`mio_oe` = 1). `mio_o[0]` equals `rx_full` (1 = no room for a write). `miso_oe` is 1 and `miso_o` equals `tx_empty` (1 = nothing to read).
- R2: With `ss_n` high and `status_en` low, `mio_oe` is all zeros and `miso_oe` is 0.
- R3: After `ss_n` falls, the command is taken from `mio_i[0]` on 8 rising edges, most significant bit first. Command bit 0 is the direction (1 = read, 0 = write). Bits 2:1 are the lane code (00 = 1 lane, 01 = 2, 10 = 4, 11 = 8). During the command the slave does not drive the data bus, and `miso_o` is 0.
- R4: In a write, each byte arrives as 8/W chunks on `mio_i[W-1:0]`, most significant chunk first, one chunk per rising edge. On the edge of the last chunk, if `rx_full` is low, `rx_push` is high and `rx_data` holds the whole byte.
- R5: In a read, the first rising edge after the command is a turnaround: the slave does not drive, and it loads the first byte with `tx_pop`. From the next falling edge on, `mio_oe` enables lanes W-1..0 and `mio_o` carries the loaded byte, most significant chunk first. Each chunk is held from one falling edge to the next. The next byte is loaded on the edge that completes the current one.
- R6: From the falling edge after each byte decision, `miso_o` shows 0 for ACK and 1 for NAK. A write byte is NAKed when `rx_full` is high at its last chunk. A read load is NAKed when `tx_empty` is high.
- R7: After a NAK, `miso_o` stays 1. There is no further `rx_push` or `tx_pop`, and the slave stops driving the data bus until `ss_n` rises.
- R8: When `ss_n` rises at any time, the slave releases the transaction drive without waiting for a clock edge. The next select starts a fresh command.
- R9: Any number of bytes may follow one command while `ss_n` stays low, with no gap cycles between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Bus clock from the master |
| rst_n | input | 1 | Asynchronous active-low reset |
| ss_n | input | 1 | Active-low select from the master |
| status_en | input | 1 | Enables FIFO status driving while deselected |
| mio_i | input | DW | Data bus input lanes |
| mio_o | output | DW | Data bus output lanes |
| mio_oe | output | DW | Per-lane output enable of the data bus |
| miso_o | output | 1 | Status line value (ACK/NAK or idle status) |
| miso_oe | output | 1 | Status line output enable |
| tx_empty | input | 1 | Transmit FIFO has no data |
| tx_data | input | DW | Head byte of the transmit FIFO |
| tx_pop | output | 1 | Takes the head byte of the transmit FIFO on this edge |
| rx_full | input | 1 | Receive FIFO has no room |
| rx_data | output | DW | Byte offered to the receive FIFO |
| rx_push | output | 1 | Writes `rx_data` into the receive FIFO on this edge |

## Verification
The bench uses the default parameters: an 8-bit byte and an 8-bit command. All four lane codes can therefore be reached, from the 8-chunk serial byte down to the single-chunk full-width byte, which loads a new byte on every rising edge. The bench's FIFO models have a small, randomly chosen receive capacity and a randomly chosen transmit fill. This puts the NAK in both directions, and the sticky behaviour after a NAK, in reach within a few bytes. One directed case raises the select between clock edges in the middle of a read.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
  typedef enum logic [2:0] {
    ST_CMD  = 3'd0,
    ST_TURN = 3'd1,
    ST_WR   = 3'd2,
    ST_RD   = 3'd3,
    ST_HALT = 3'd4
  } hdx_state_e;

  typedef logic [1:0] lane_code_t;
endpackage

// File: rtl/hdx_chunk.sv
module hdx_chunk #(
  parameter int DW    = 8,
  parameter int CNT_W = 3
) (
  input  logic [DW-1:0]    data_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic [1:0]       code_i,
  output logic [DW-1:0]    lane_o
);
  logic [DW-1:0] shifted;
  int unsigned   wbits;

  always_comb begin
    wbits   = 32'd1 << code_i;
    // chunk idx_i counted from the most significant end
    shifted = data_i << (32'(idx_i) * wbits);
    lane_o  = shifted >> (DW - wbits);
  end
endmodule

// File: rtl/hdx_ctrl.sv
module hdx_ctrl
  import hdx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CW    = 8,
  parameter int CNT_W = 3
) (
  input  logic             sclk,
  input  logic             arst_n,
  input  logic [DW-1:0]    mio_i,
  input  logic             tx_empty,
  input  logic [DW-1:0]    tx_data,
  input  logic             rx_full,
  output hdx_state_e       st_o,
  output lane_code_t       code_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [DW-1:0]    rd_byte_o,
  output logic             nak_o,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [DW-1:0]    rx_data
);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CW - 1);

  hdx_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, last_cnt;
  logic [CW-1:0]    cmd_q, cmd_d, cmd_shift;
  lane_code_t       code_q, code_d;
  logic [DW-1:0]    rd_q, rd_d, wr_q, wr_d, wr_asm, lane_mask;
  logic             nak_q, nak_d, fetch;
  logic             cmd_en, wr_en, rd_en, code_en;
  int unsigned      wbits;

  always_comb begin
    wbits     = 32'd1 << code_q;
    lane_mask = ~({DW{1'b1}} << wbits);
    last_cnt  = CNT_W'((DW >> code_q) - 1);
    cmd_shift = {cmd_q[CW-2:0], mio_i[0]};
    wr_asm    = DW'(wr_q << wbits) | (mio_i & lane_mask);
  end

  // next-state logic
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    cmd_d   = cmd_shift;
    code_d  = code_q;
    rd_d    = rd_q;
    wr_d    = wr_q;
    nak_d   = nak_q;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    fetch   = 1'b0;
    unique case (st_q)
      ST_CMD: begin
        if (cnt_q == CMD_LAST) begin
          code_d = cmd_shift[2:1];
          cnt_d  = '0;
          st_d   = cmd_shift[0] ? ST_TURN : ST_WR;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_TURN: fetch = 1'b1;
      ST_RD: begin
        if (cnt_q == last_cnt) fetch = 1'b1;
        else                   cnt_d = cnt_q + 1'b1;
      end
      ST_WR: begin
        if (cnt_q == last_cnt) begin
          cnt_d = '0;
          wr_d  = '0;
          if (rx_full) begin
            nak_d = 1'b1;
            st_d  = ST_HALT;
          end else begin
            rx_push = 1'b1;
          end
        end else begin
          wr_d  = wr_asm;
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_HALT: ;
      default: st_d = ST_HALT;
    endcase
    if (fetch) begin
      cnt_d = '0;
      if (tx_empty) begin
        nak_d = 1'b1;
        st_d  = ST_HALT;
      end else begin
        tx_pop = 1'b1;
        rd_d   = tx_data;
        st_d   = ST_RD;
      end
    end
  end

  assign cmd_en  = (st_q == ST_CMD);
  assign code_en = cmd_en && (cnt_q == CMD_LAST);
  assign wr_en   = (st_q == ST_WR);
  assign rd_en   = tx_pop;

  // registers
  always_ff @(posedge sclk or negedge arst_n) begin
    if (!arst_n) begin
      st_q   <= ST_CMD;
      cnt_q  <= '0;
      cmd_q  <= '0;
      code_q <= '0;
      rd_q   <= '0;
      wr_q   <= '0;
      nak_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      nak_q <= nak_d;
      if (cmd_en)  cmd_q  <= cmd_d;
      if (code_en) code_q <= code_d;
      if (rd_en)   rd_q   <= rd_d;
      if (wr_en)   wr_q   <= wr_d;
    end
  end

  assign st_o      = st_q;
  assign code_o    = code_q;
  assign cnt_o     = cnt_q;
  assign rd_byte_o = rd_q;
  assign nak_o     = nak_q;
  assign rx_data   = wr_asm;
endmodule

// File: rtl/hdx_drive.sv
module hdx_drive
  import hdx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 3
) (
  input  logic             sclk,
  input  logic             arst_n,
  input  logic             ss_n,
  input  logic             status_en,
  input  hdx_state_e       st_i,
  input  lane_code_t       code_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [DW-1:0]    rd_byte_i,
  input  logic             nak_i,
  input  logic             rx_full,
  input  logic             tx_empty,
  output logic [DW-1:0]    mio_o,
  output logic [DW-1:0]    mio_oe,
  output logic             miso_o,
  output logic             miso_oe
);
  logic [DW-1:0] lane_d, lane_q, lane_mask;
  logic          drv_d, drv_q, ack_d, ack_q;

  hdx_chunk #(.DW(DW), .CNT_W(CNT_W)) i_chunk (
    .data_i (rd_byte_i),
    .idx_i  (cnt_i),
    .code_i (code_i),
    .lane_o (lane_d)
  );

  always_comb begin
    drv_d     = (st_i == ST_RD);
    ack_d     = nak_i;
    lane_mask = ~({DW{1'b1}} << (32'd1 << code_i));
  end

  // falling-edge launch of everything the master samples
  always_ff @(negedge sclk or negedge arst_n) begin
    if (!arst_n) begin
      lane_q <= '0;
      drv_q  <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      lane_q <= lane_d;
      drv_q  <= drv_d;
      ack_q  <= ack_d;
    end
  end

  always_comb begin
    if (ss_n) begin
      mio_o   = {{(DW-1){1'b0}}, rx_full};
      mio_oe  = {{(DW-1){1'b0}}, status_en};
      miso_o  = tx_empty;
      miso_oe = status_en;
    end else begin
      mio_o   = drv_q ? lane_q : '0;
      mio_oe  = drv_q ? lane_mask : '0;
      miso_o  = ack_q;
      miso_oe = 1'b1;
    end
  end
endmodule

// File: rtl/hdx_slave.sv
module hdx_slave
  import hdx_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          sclk,
  input  logic          rst_n,
  input  logic          ss_n,
  input  logic          status_en,
  input  logic [DW-1:0] mio_i,
  output logic [DW-1:0] mio_o,
  output logic [DW-1:0] mio_oe,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          tx_empty,
  input  logic [DW-1:0] tx_data,
  output logic          tx_pop,
  input  logic          rx_full,
  output logic [DW-1:0] rx_data,
  output logic          rx_push
);
  localparam int CNT_W = $clog2((CW > DW) ? CW : DW);

  logic             sess_rst_n;
  hdx_state_e       st;
  lane_code_t       code;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    rd_byte;
  logic             nak;

  // a released select clears the transaction at once
  assign sess_rst_n = rst_n & ~ss_n;

  hdx_ctrl #(.DW(DW), .CW(CW), .CNT_W(CNT_W)) i_ctrl (
    .sclk      (sclk),
    .arst_n    (sess_rst_n),
    .mio_i     (mio_i),
    .tx_empty  (tx_empty),
    .tx_data   (tx_data),
    .rx_full   (rx_full),
    .st_o      (st),
    .code_o    (code),
    .cnt_o     (cnt),
    .rd_byte_o (rd_byte),
    .nak_o     (nak),
    .tx_pop    (tx_pop),
    .rx_push   (rx_push),
    .rx_data   (rx_data)
  );

  hdx_drive #(.DW(DW), .CNT_W(CNT_W)) i_drive (
    .sclk      (sclk),
    .arst_n    (sess_rst_n),
    .ss_n      (ss_n),
    .status_en (status_en),
    .st_i      (st),
    .code_i    (code),
    .cnt_i     (cnt),
    .rd_byte_i (rd_byte),
    .nak_i     (nak),
    .rx_full   (rx_full),
    .tx_empty  (tx_empty),
    .mio_o     (mio_o),
    .mio_oe    (mio_oe),
    .miso_o    (miso_o),
    .miso_oe   (miso_oe)
  );
endmodule

// File: rtl/hdx_slave_chk.sv
module hdx_slave_chk #(
  parameter int DW = 8
) (
  input logic          sclk,
  input logic          rst_n,
  input logic          ss_n,
  input logic          status_en,
  input logic [DW-1:0] mio_oe,
  input logic          miso_o,
  input logic          miso_oe,
  input logic          rx_full,
  input logic          rx_push,
  input logic          tx_empty,
  input logic          tx_pop
);
  // R6
  push_room_chk: assert property (@(posedge sclk) disable iff (!rst_n || ss_n)
    rx_push |-> !rx_full);

  // R6
  pop_data_chk: assert property (@(posedge sclk) disable iff (!rst_n || ss_n)
    tx_pop |-> !tx_empty);

  // R4
  one_way_chk: assert property (@(posedge sclk) disable iff (!rst_n || ss_n)
    rx_push |-> (!tx_pop && mio_oe == '0));

  // R2
  quiet_idle_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (ss_n && !status_en) |-> (mio_oe == '0 && !miso_oe));

  // R7
  nak_hold_chk: assert property (@(negedge sclk) disable iff (!rst_n || ss_n)
    miso_o |=> miso_o);

  // R7
  nak_frozen_chk: assert property (@(posedge sclk) disable iff (!rst_n || ss_n)
    miso_o |-> (!rx_push && !tx_pop && mio_oe == '0));

  // R5
  lane_shape_chk: assert property (@(negedge sclk) disable iff (!rst_n || ss_n)
    (mio_oe != '0) |-> ((mio_oe & (mio_oe + 1'b1)) == '0 && mio_oe[0]));
endmodule

bind hdx_slave hdx_slave_chk #(.DW(DW)) i_hdx_chk (
  .sclk      (sclk),
  .rst_n     (rst_n),
  .ss_n      (ss_n),
  .status_en (status_en),
  .mio_oe    (mio_oe),
  .miso_o    (miso_o),
  .miso_oe   (miso_oe),
  .rx_full   (rx_full),
  .rx_push   (rx_push),
  .tx_empty  (tx_empty),
  .tx_pop    (tx_pop)
);

// File: tb/test_hdx_slave.sv
module test_hdx_slave;
  logic       sclk = 1'b0;
  logic       rst_n, ss_n, status_en;
  logic [7:0] mio_i, mio_o, mio_oe, tx_data, rx_data;
  logic       miso_o, miso_oe, tx_empty, tx_pop, rx_full, rx_push;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  int         rx_cap = 4;

  always #5 sclk = ~sclk;

  hdx_slave i_hdx_slave (
    .sclk(sclk), .rst_n(rst_n), .ss_n(ss_n), .status_en(status_en),
    .mio_i(mio_i), .mio_o(mio_o), .mio_oe(mio_oe),
    .miso_o(miso_o), .miso_oe(miso_oe),
    .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_full(rx_full), .rx_data(rx_data), .rx_push(rx_push)
  );

  function automatic void refresh();
    tx_empty = (txq.size() == 0);
    tx_data  = tx_empty ? 8'h00 : txq[0];
    rx_full  = (rxq.size() >= rx_cap);
  endfunction

  // FIFO models: strobes sampled just before the rising edge
  always begin
    logic p, q;
    logic [7:0] d;
    @(negedge sclk);
    #4;
    p = tx_pop; q = rx_push; d = rx_data;
    @(posedge sclk);
    if (p && txq.size() > 0) void'(txq.pop_front());
    if (q) rxq.push_back(d);
    #1 refresh();
  end

  function automatic int chunk_of(input logic [7:0] d, input int c, input int w);
    int v;
    v = (int'(d) << (c * w)) & 255;
    return v >> (8 - w);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge sclk);
    @(negedge sclk);
    #1;
  endtask

  task automatic send_cmd(input int code, input bit rd);
    logic [7:0] c;
    c = {5'b0, 2'(code), rd};
    ss_n = 1'b0;
    for (int b = 7; b >= 0; b--) begin
      mio_i = {7'b0, c[b]};
      tick();
      if (b == 4) chk("R3 no drive during command", int'(mio_oe), 0);
    end
  endtask

  task automatic do_write(input int code, input int n);
    int w, base, acc;
    bit nk;
    logic [7:0] d;
    w = 1 << code; acc = 0; nk = 1'b0;
    send_cmd(code, 1'b0);
    chk("R3 write cmd leaves bus free", int'(mio_oe), 0);
    chk("R3 miso low after command", int'(miso_o), 0);
    base = rxq.size();
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      for (int c = 0; c < 8 / w; c++) begin
        mio_i = 8'(chunk_of(d, c, w));
        tick();
      end
      if (!nk && base + acc < rx_cap) acc++;
      else nk = 1'b1;
      chk("R6 write ack/nak", int'(miso_o), int'(nk));
      chk(i > 0 ? "R9 R7 write count" : "R7 write count", rxq.size(), base + acc);
      if (!nk) chk("R4 write byte", int'(rxq[rxq.size()-1]), int'(d));
    end
    ss_n = 1'b1; mio_i = '0;
    tick();
  endtask

  task automatic do_read(input int code, input int n);
    int w, avail, pops;
    bit nk;
    logic [7:0] src[$];
    w = 1 << code;
    src = txq;
    avail = txq.size();
    send_cmd(code, 1'b1);
    chk("R5 turnaround not driven", int'(mio_oe), 0);
    mio_i = '0;
    tick();
    for (int i = 0; ; i++) begin
      nk = (i >= avail);
      pops = (i + 1 < avail) ? i + 1 : avail;
      chk("R6 read ack/nak", int'(miso_o), int'(nk));
      chk("R5 pop count", avail - txq.size(), pops);
      if (nk) begin
        chk("R7 bus released after nak", int'(mio_oe), 0);
        break;
      end
      if (i == n) break;
      for (int c = 0; c < 8 / w; c++) begin
        chk("R5 lane enable", int'(mio_oe), (1 << w) - 1);
        chk(i > 0 ? "R9 R5 read chunk" : "R5 read chunk", int'(mio_o), chunk_of(src[i], c, w));
        tick();
      end
    end
    ss_n = 1'b1;
    tick();
  endtask

  task automatic fill_tx(input int k);
    for (int i = 0; i < k; i++) txq.push_back(8'($urandom));
    refresh();
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1248));
    rst_n = 1'b0; ss_n = 1'b0; status_en = 1'b0; mio_i = '0;
    refresh();
    @(negedge sclk); #1;
    tick();
    chk("R8 reset: no drive", int'(mio_oe), 0);
    chk("R8 reset: ack low", int'(miso_o), 0);
    ss_n = 1'b1;
    tick();
    rst_n = 1'b1;
    tick();

    // R2 quiet idle
    chk("R2 idle lanes off", int'(mio_oe), 0);
    chk("R2 idle miso off", int'(miso_oe), 0);

    // R1 status while idle
    status_en = 1'b1;
    rx_cap = 0; refresh();
    tick();
    chk("R1 lane0 only", int'(mio_oe), 1);
    chk("R1 full flag", int'(mio_o[0]), 1);
    chk("R1 miso enabled", int'(miso_oe), 1);
    chk("R1 empty flag", int'(miso_o), 1);
    rx_cap = 4; fill_tx(1);
    tick();
    chk("R1 room flag", int'(mio_o[0]), 0);
    chk("R1 data flag", int'(miso_o), 0);
    txq.delete(); refresh();
    status_en = 1'b0;

    // directed: every width, write and read, several bytes
    for (int code = 0; code < 4; code++) begin
      rxq.delete(); rx_cap = 8; refresh();
      do_write(code, 3);
      txq.delete(); fill_tx(5);
      do_read(code, 3);
    end

    // R6/R7 write NAK then ignored bytes
    rxq.delete(); rx_cap = 1; refresh();
    do_write(1, 3);
    // R6/R7 read runs dry
    txq.delete(); fill_tx(2);
    do_read(2, 4);
    // read from empty FIFO: NAK at turnaround
    txq.delete(); refresh();
    do_read(0, 1);

    // R8 select released between edges in mid read
    txq.delete(); fill_tx(3);
    send_cmd(0, 1'b1);
    tick(); tick(); tick();
    #2 ss_n = 1'b1;
    #1;
    chk("R8 async release lanes", int'(mio_oe), 0);
    chk("R8 async release miso", int'(miso_oe), 0);
    tick();
    rxq.delete(); rx_cap = 8; refresh();
    do_write(3, 2);
    chk("R8 fresh command after release", rxq.size(), 2);

    // random mix
    for (int t = 0; t < 40; t++) begin
      int code, n;
      code = int'($urandom_range(0, 3));
      n    = int'($urandom_range(1, 6));
      status_en = 1'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        rxq.delete(); rx_cap = int'($urandom_range(0, 5)); refresh();
        do_write(code, n);
      end else begin
        txq.delete(); fill_tx(int'($urandom_range(0, 6)));
        do_read(code, n);
      end
      if (status_en) begin
        chk("R1 status after transaction", int'(miso_o), int'(txq.size() == 0));
      end else begin
        chk("R2 quiet after transaction", int'(mio_oe), 0);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule